// File: doc/BRIEF.md
# RS-485 UART Transmitter with Hardware Bus Turnaround

This block is the transmit half of a UART meant for a half-duplex RS-485 segment. Bytes are handed over through a valid/ready write port into a one-byte holding register. A shift register sends each byte as an 8N1 frame, paced by an external baud tick. The transceiver driver-enable is derived directly from the shift register's activity. The bus is therefore claimed on the clock edge on which the start bit appears and released as soon as the stop bit ends, with no software polling.

The driver-enable pin comes with its own output-enable, so it stays tristated after reset until software sets the direction-output bit. Until then an external pull resistor keeps the transceiver in receive mode. The active level of driver-enable can be inverted for transceivers with inverted control.

A transmitter-empty status bit and a level-sensitive, maskable shift-empty interrupt let software learn when a message has fully left the wire. Write back-pressure is simple: `wr_ready` is high exactly when the holding register is empty. A byte is taken on a clock edge where `wr_valid` and `wr_ready` are both high. While `wr_ready` is low the offered byte is not taken, and the stored byte is left unchanged.

Top module: `rs485_uart_tx`

## Requirements
- R1: Each frame is a start bit of 0, then eight data bits least significant bit first, then a stop bit of 1. Each bit lasts 16 baud ticks, counted from the edge on which the frame is loaded. The idle line level is 1.
- R2: Driver-enable becomes active on the same clock edge on which the start bit first appears on `tx_line`. It stays active through the whole stop bit and becomes inactive on the edge where the stop bit ends.
- R3: If the holding register is full when a stop bit ends, the next start bit begins on that same edge and driver-enable stays active without a gap.
- R4: `tx_empty` is 1 only when both the holding register and the shift register are empty.
- R5: When `irq_en` is 1, `shift_irq` goes to 1 on the edge where the shift register becomes empty, and it stays at 1 as a level.
- R6: `shift_irq` is cleared by an accepted byte write or by `irq_en` being 0. If a write is accepted on the same edge on which the shift register empties, the write wins and `shift_irq` stays 0.
- R7: After reset, `drv_oe` is 0, `tx_line` is 1, `tx_empty` is 1, `shift_irq` is 0 and `wr_ready` is 1.
- R8: While `dir_en` is 0, `tx_line` is held at 1 and `drv_oe` is 0, even while the shifter runs. While `dir_en` is 1, `drv_oe` is 1.
- R9: With `de_active_low` = 0, driver-enable is active high on `drv_en`. With `de_active_low` = 1, `drv_en` is 0 while active and 1 while idle.
- R10: `wr_ready` is 1 exactly while the holding register is empty. A write offered while `wr_ready` is 0 is not taken, and the byte already held is the one sent next.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| wr_valid | input | 1 | Byte write offered |
| wr_ready | output | 1 | Holding register empty, write can be taken |
| wr_data | input | 8 | Byte to send |
| baud_tick | input | 1 | One pulse per oversample period (16 per bit) |
| dir_en | input | 1 | Direction-output enable: drives the driver-enable pin and the TX line |
| de_active_low | input | 1 | Driver-enable polarity select |
| irq_en | input | 1 | Shift-empty interrupt mask |
| tx_line | output | 1 | Serial transmit data |
| drv_en | output | 1 | Transceiver driver-enable level |
| drv_oe | output | 1 | Output-enable of the driver-enable pin (0 = tristate) |
| tx_empty | output | 1 | Holding and shift registers both empty |
| shift_irq | output | 1 | Level interrupt: shift register has gone empty |

## Verification
Two functions can fall on the same edge: the end of a stop bit, which empties the shift register and would raise the interrupt, and the acceptance of a new byte, which must clear it. The bench presents a write exactly on the clock edge that ends a stop bit while the holding register is empty. It then judges that the interrupt stays low, that `tx_empty` is 0 and that the new frame's start bit follows one edge later. A second coincidence, a stop bit ending while a byte is already held, is judged by driver-enable staying active across the boundary with the new start bit on the same edge.

// File: rtl/rs485_pkg.sv
package rs485_pkg;
  localparam int unsigned UART_DW  = 8;
  localparam int unsigned UART_OVS = 16;
endpackage

// File: rtl/rs485_tx_hold.sv
module rs485_tx_hold #(
  parameter int unsigned DW = rs485_pkg::UART_DW
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          wr_valid,
  output logic          wr_ready,
  input  logic [DW-1:0] wr_data,
  input  logic          take,
  output logic          full,
  output logic [DW-1:0] data
);
  assign wr_ready = !full;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      full <= 1'b0;
      data <= '0;
    end else if (take) begin
      full <= 1'b0;
    end else if (wr_valid && !full) begin
      full <= 1'b1;
      data <= wr_data;
    end
  end

  assert_no_overwrite_R10: assert property (@(posedge clk) disable iff (!rst_n)
    (full && !take) |=> (full && $stable(data)));
endmodule

// File: rtl/rs485_tx_shift.sv
module rs485_tx_shift #(
  parameter int unsigned DW  = rs485_pkg::UART_DW,
  parameter int unsigned OVS = rs485_pkg::UART_OVS
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          baud_tick,
  input  logic          hold_full,
  input  logic [DW-1:0] hold_data,
  output logic          load,
  output logic          busy,
  output logic          frame_end,
  output logic          tx_raw
);
  localparam int unsigned FRAME_W = DW + 2;
  localparam int unsigned IDX_W   = $clog2(FRAME_W);
  localparam int unsigned CNT_W   = $clog2(OVS);
  localparam logic [CNT_W-1:0] CNT_LAST = CNT_W'(OVS - 1);
  localparam logic [IDX_W-1:0] IDX_LAST = IDX_W'(FRAME_W - 1);

  logic [FRAME_W-1:0] shreg;
  logic [CNT_W-1:0]   tick_cnt;
  logic [IDX_W-1:0]   bit_idx;

  assign frame_end = busy && baud_tick && (tick_cnt == CNT_LAST) && (bit_idx == IDX_LAST);
  assign load      = hold_full && (!busy || frame_end);
  assign tx_raw    = shreg[0];

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      busy     <= 1'b0;
      shreg    <= '1;
      tick_cnt <= '0;
      bit_idx  <= '0;
    end else if (load) begin
      busy     <= 1'b1;
      shreg    <= {1'b1, hold_data, 1'b0};
      tick_cnt <= '0;
      bit_idx  <= '0;
    end else if (frame_end) begin
      busy     <= 1'b0;
      shreg    <= '1;
      tick_cnt <= '0;
      bit_idx  <= '0;
    end else if (busy && baud_tick) begin
      if (tick_cnt == CNT_LAST) begin
        tick_cnt <= '0;
        bit_idx  <= bit_idx + 1'b1;
        shreg    <= {1'b1, shreg[FRAME_W-1:1]};
      end else begin
        tick_cnt <= tick_cnt + 1'b1;
      end
    end
  end

  assert_start_bit_R2: assert property (@(posedge clk) disable iff (!rst_n)
    load |=> (busy && !tx_raw));
  assert_back_to_back_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (frame_end && hold_full) |=> busy);
  assert_idle_high_R1: assert property (@(posedge clk) disable iff (!rst_n)
    !busy |-> tx_raw);
endmodule

// File: rtl/rs485_tx_dir.sv
module rs485_tx_dir (
  input  logic clk,
  input  logic rst_n,
  input  logic dir_en,
  input  logic de_active_low,
  input  logic irq_en,
  input  logic busy,
  input  logic tx_raw,
  input  logic frame_end,
  input  logic hold_full,
  input  logic wr_fire,
  output logic tx_line,
  output logic drv_en,
  output logic drv_oe,
  output logic tx_empty,
  output logic shift_irq
);
  logic irq_q;

  assign tx_line   = dir_en ? tx_raw : 1'b1;
  assign drv_en    = busy ^ de_active_low;
  assign drv_oe    = dir_en;
  assign tx_empty  = !hold_full && !busy;
  assign shift_irq = irq_q;

  always_ff @(posedge clk) begin
    if (!rst_n)                       irq_q <= 1'b0;
    else if (!irq_en)                 irq_q <= 1'b0;
    else if (wr_fire)                 irq_q <= 1'b0;
    else if (frame_end && !hold_full) irq_q <= 1'b1;
  end

  assert_irq_when_idle_R5: assert property (@(posedge clk) disable iff (!rst_n)
    irq_q |-> !busy);
  assert_irq_masked_R6: assert property (@(posedge clk) disable iff (!rst_n)
    !irq_en |=> !irq_q);
endmodule

// File: rtl/rs485_uart_tx.sv
module rs485_uart_tx #(
  parameter int unsigned DW  = rs485_pkg::UART_DW,
  parameter int unsigned OVS = rs485_pkg::UART_OVS
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          wr_valid,
  output logic          wr_ready,
  input  logic [DW-1:0] wr_data,
  input  logic          baud_tick,
  input  logic          dir_en,
  input  logic          de_active_low,
  input  logic          irq_en,
  output logic          tx_line,
  output logic          drv_en,
  output logic          drv_oe,
  output logic          tx_empty,
  output logic          shift_irq
);
  logic          hold_full, load, busy, frame_end, tx_raw;
  logic [DW-1:0] hold_data;

  rs485_tx_hold #(.DW(DW)) u_hold (
    .clk(clk), .rst_n(rst_n), .wr_valid(wr_valid), .wr_ready(wr_ready),
    .wr_data(wr_data), .take(load), .full(hold_full), .data(hold_data)
  );

  rs485_tx_shift #(.DW(DW), .OVS(OVS)) u_shift (
    .clk(clk), .rst_n(rst_n), .baud_tick(baud_tick), .hold_full(hold_full),
    .hold_data(hold_data), .load(load), .busy(busy), .frame_end(frame_end),
    .tx_raw(tx_raw)
  );

  rs485_tx_dir u_dir (
    .clk(clk), .rst_n(rst_n), .dir_en(dir_en), .de_active_low(de_active_low),
    .irq_en(irq_en), .busy(busy), .tx_raw(tx_raw), .frame_end(frame_end),
    .hold_full(hold_full), .wr_fire(wr_valid && wr_ready),
    .tx_line(tx_line), .drv_en(drv_en), .drv_oe(drv_oe),
    .tx_empty(tx_empty), .shift_irq(shift_irq)
  );

  assert_empty_means_ready_R4: assert property (@(posedge clk) disable iff (!rst_n)
    tx_empty |-> wr_ready);
endmodule

// File: tb/sim_rs485_uart_tx.sv
module sim_rs485_uart_tx;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       wr_valid = 1'b0;
  logic [7:0] wr_data = '0;
  logic       baud_tick = 1'b1;
  logic       dir_en = 1'b0;
  logic       de_active_low = 1'b0;
  logic       irq_en = 1'b0;
  logic       wr_ready, tx_line, drv_en, drv_oe, tx_empty, shift_irq;
  int         n_chk = 0;
  int         n_bad = 0;

  always #10 clk = ~clk;

  rs485_uart_tx u0 (
    .clk(clk), .rst_n(rst_n), .wr_valid(wr_valid), .wr_ready(wr_ready),
    .wr_data(wr_data), .baud_tick(baud_tick), .dir_en(dir_en),
    .de_active_low(de_active_low), .irq_en(irq_en), .tx_line(tx_line),
    .drv_en(drv_en), .drv_oe(drv_oe), .tx_empty(tx_empty), .shift_irq(shift_irq)
  );

  // {data[7:0], de_active_low, irq_en}
  localparam logic [9:0] VEC [0:5] = '{
    {8'hA5, 1'b0, 1'b1}, {8'h00, 1'b1, 1'b1}, {8'hFF, 1'b0, 1'b0},
    {8'h3C, 1'b1, 1'b0}, {8'h81, 1'b0, 1'b1}, {8'h5A, 1'b0, 1'b1}
  };

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s: actual %0h expected %0h at %0t", req, act, exp, $time);
    end
  endtask

  // n rising edges, then settle at the following falling edge
  task automatic advance(input int n);
    repeat (n) @(posedge clk);
    @(negedge clk);
  endtask

  // called at a falling edge; returns after the accepting edge
  task automatic send(input logic [7:0] d);
    wr_data  = d;
    wr_valid = 1'b1;
    advance(1);
    wr_valid = 1'b0;
  endtask

  // called just after the load edge; returns at mid stop bit
  task automatic frame_bits(input logic [7:0] d, input logic pol);
    for (int k = 0; k < 10; k++) begin
      logic e;
      advance(k == 0 ? 8 : 16);
      e = (k == 0) ? 1'b0 : (k == 9) ? 1'b1 : d[k-1];
      chk("R1 frame bit", 32'(tx_line), 32'(e));
      chk("R2 de active in frame", 32'(drv_en), 32'(!pol));
    end
  endtask

  initial begin
    #4000000;
    n_bad++;
    $display("FAIL watchdog: actual hung expected done");
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end

  initial begin
    advance(3);
    // R7 reset state
    chk("R7 drv_oe", 32'(drv_oe), 0);
    chk("R7 tx_line", 32'(tx_line), 1);
    chk("R7 tx_empty", 32'(tx_empty), 1);
    chk("R7 shift_irq", 32'(shift_irq), 0);
    chk("R7 wr_ready", 32'(wr_ready), 1);
    rst_n = 1'b1;
    advance(2);
    chk("R7 still tristate", 32'(drv_oe), 0);
    dir_en = 1'b1;
    advance(0);
    chk("R8 drv_oe on", 32'(drv_oe), 1);

    for (int i = 0; i < 6; i++) begin
      logic [7:0] d;
      logic pol, ie;
      d = VEC[i][9:2]; pol = VEC[i][1]; ie = VEC[i][0];
      de_active_low = pol;
      irq_en = ie;
      send(d);
      chk("R10 ready low when held", 32'(wr_ready), 0);
      chk("R4 not empty", 32'(tx_empty), 0);
      chk("R6 irq cleared by write", 32'(shift_irq), 0);
      chk("R9 de idle level", 32'(drv_en), 32'(pol));
      chk("R1 idle before load", 32'(tx_line), 1);
      advance(1);
      chk("R2 start with de", 32'(tx_line), 0);
      chk("R9 de active level", 32'(drv_en), 32'(!pol));
      chk("R10 ready after load", 32'(wr_ready), 1);
      frame_bits(d, pol);
      advance(7);
      chk("R2 de held to stop end", 32'(drv_en), 32'(!pol));
      chk("R1 stop high", 32'(tx_line), 1);
      advance(1);
      chk("R2 de released", 32'(drv_en), 32'(pol));
      chk("R4 empty after frame", 32'(tx_empty), 1);
      chk("R5 irq level", 32'(shift_irq), 32'(ie));
    end

    // R6 mask clear drops the interrupt
    irq_en = 1'b0;
    advance(1);
    chk("R6 irq cleared by mask", 32'(shift_irq), 0);
    irq_en = 1'b1;
    advance(3);
    chk("R5 no irq without new empty", 32'(shift_irq), 0);

    // R3 back to back, R10 back-pressure
    de_active_low = 1'b0;
    send(8'h96);
    advance(1);                      // after S
    send(8'h4B);                     // after S+1
    chk("R10 ready low while held", 32'(wr_ready), 0);
    wr_data = 8'hFF; wr_valid = 1'b1;
    advance(20);                     // after S+21
    wr_valid = 1'b0;
    advance(138);                    // after S+159
    chk("R3 de in stop", 32'(drv_en), 1);
    chk("R3 stop high", 32'(tx_line), 1);
    advance(1);                      // after S+160
    chk("R3 de no gap", 32'(drv_en), 1);
    chk("R3 next start same edge", 32'(tx_line), 0);
    chk("R5 no irq between frames", 32'(shift_irq), 0);
    frame_bits(8'h4B, 1'b0);
    chk("R10 held byte kept", 32'(tx_line), 1);
    advance(8);
    chk("R2 de released after pair", 32'(drv_en), 0);
    chk("R5 irq after pair", 32'(shift_irq), 1);

    // R6 write on the emptying edge
    send(8'h11);
    advance(1);                      // after S
    advance(159);                    // after S+159
    wr_data = 8'h22; wr_valid = 1'b1;
    advance(1);                      // after S+160
    wr_valid = 1'b0;
    chk("R6 write wins over irq", 32'(shift_irq), 0);
    chk("R4 not empty on coincidence", 32'(tx_empty), 0);
    chk("R2 de dropped at end", 32'(drv_en), 0);
    advance(1);
    chk("R2 new start", 32'(tx_line), 0);
    chk("R2 de back on", 32'(drv_en), 1);
    advance(160);
    chk("R5 irq after coincidence frame", 32'(shift_irq), 1);

    // R8 direction disabled
    dir_en = 1'b0;
    send(8'h00);
    advance(1);
    chk("R8 tx held high", 32'(tx_line), 1);
    chk("R8 oe low", 32'(drv_oe), 0);
    advance(8);
    chk("R8 tx high mid start", 32'(tx_line), 1);
    advance(152);
    chk("R4 empty after silent frame", 32'(tx_empty), 1);

    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end
endmodule